// File: doc/BRIEF.md
# Multi-Channel Serial Command Engine

This engine runs one command transaction at a time towards one of four serial tone coder devices. All four devices share a serial clock line, a data-out line and a data-in line. Each device has its own active-low select. The host places a channel number, a command byte and two optional parameter bytes on the inputs and pulses `start`.

The engine looks up the command byte to decide how many bytes follow and in which direction they travel. It then runs the whole bus sequence with fixed, microsecond-scaled delays and ends with a single-cycle `done`. A command that reads back leaves the returned byte on `rdata`. A request for a channel that does not exist, or for a command byte outside the known set, ends straight away with `done` and `err` and causes no bus activity.

All delays count system clock cycles. The parameter `CYC_PER_US` sets how many cycles make up one microsecond.

Top module: `sce_engine`

## Requirements
- R1: A request whose channel number is 4 or higher is answered in the next cycle with `done` and `err` both high. No select line goes low and the serial clock does not move.
- R2: The command byte is classified as follows. 0x01 has no parameter bytes. 0x80 through 0x87 write one parameter byte. 0x00, 0xC0 and 0xC1 read one byte. 0xB0 through 0xB3 write two parameter bytes. Every other value is rejected in the same way as in R1.
- R3: The data-out line is high when a select falls. During a transaction only the select of the addressed channel (bit n of `sel_n` for channel n) is low, and the other three stay high.
- R4: The command byte goes first, then `wbyte0`, then `wbyte1`, for as many bytes as the class in R2 needs. Each byte is sent most significant bit first, 8 bits per byte.
- R5: The serial clock idles high. For every bit the data-out value is set before the clock falls, and it does not change while the clock is low, so the device samples it on the rising edge.
- R6: On a read, each bit starts with a full low-then-high clock pulse. The data-in line is sampled 2 µs after that pulse and shifted into bit 0 of the result, so the first bit received ends up in bit 7 of `rdata`. `rdata` holds the byte after `done`.
- R7: The timing, with T = `CYC_PER_US` cycles, is as follows: 2T with data high before the select falls, 2T from the select falling to the first bit, and 4T per bit made of 2T setup, T low and T high. Consecutive bytes are separated by a 4T gap. For N bytes, `done` is seen 8T + 32T·N + 4T·(N−1) cycles after the start edge.
- R8: The last byte is followed by a 4T hold. All selects then rise together in the same cycle as a single-cycle `done` pulse.
- R9: `busy` is high from the cycle after an accepted or rejected start up to and including the `done` cycle. A `start` seen while busy is ignored, and changes to the request inputs during a transaction have no effect on it.
- R10: After reset all selects are high, the serial clock is high, data-out is high, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| chan | input | 3 | Target channel number |
| cmd | input | 8 | Command byte |
| wbyte0 | input | 8 | First parameter byte |
| wbyte1 | input | 8 | Second parameter byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected request, valid with done |
| rdata | output | 8 | Byte returned by a read command |
| sclk | output | 1 | Shared serial clock, idles high |
| mosi | output | 1 | Shared serial data to the devices |
| miso | input | 1 | Shared serial data from the devices |
| sel_n | output | 4 | Per-channel active-low selects |

## Verification
The bench sweeps all 256 command bytes on one channel. A decoder that misclassified any byte would shorten or lengthen the bit stream, or accept a byte it should reject, and both the bit count and the cycle count would show it. It also sweeps channel numbers 0 to 7. A range check written with the wrong bound would either pulse a select for channels 4 to 7 or reject channel 3. Reads are checked against a device model that changes data-in just after each rising clock edge. An engine that sampled before the pulse instead of after it would return the reply shifted by one bit. A second start is also injected in the middle of a transaction, with different inputs. A design that did not latch its request would change channel or bytes mid-stream, or would run a second transaction.

// File: rtl/sce_pkg.sv
package sce_pkg;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_WR8,
    CLS_RD8,
    CLS_WR16,
    CLS_BAD
  } cmd_class_e;

  typedef enum logic [1:0] {
    SH_HOLD,
    SH_LOAD,
    SH_OUT,
    SH_IN
  } shift_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_CSSU,
    ST_WSU,
    ST_CLO,
    ST_CHI,
    ST_RSET,
    ST_GAP,
    ST_HOLD,
    ST_DONE
  } eng_state_e;

  function automatic cmd_class_e classify(input logic [7:0] code);
    cmd_class_e c;
    case (code)
      8'h01:                                  c = CLS_NONE;
      8'h80, 8'h81, 8'h82, 8'h83,
      8'h84, 8'h85, 8'h86, 8'h87:             c = CLS_WR8;
      8'h00, 8'hC0, 8'hC1:                    c = CLS_RD8;
      8'hB0, 8'hB1, 8'hB2, 8'hB3:             c = CLS_WR16;
      default:                                c = CLS_BAD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sce_cmd_decode.sv
module sce_cmd_decode
  import sce_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 3
) (
  input  logic [7:0]      code,
  input  logic [CH_W-1:0] chan,
  output logic [1:0]      nbytes,
  output logic            is_read,
  output logic            reject
);

  cmd_class_e cls;

  always_comb begin
    cls     = classify(code);
    is_read = (cls == CLS_RD8);
    case (cls)
      CLS_NONE: nbytes = 2'd1;
      CLS_WR8:  nbytes = 2'd2;
      CLS_RD8:  nbytes = 2'd2;
      CLS_WR16: nbytes = 2'd3;
      default:  nbytes = 2'd1;
    endcase
    reject = (cls == CLS_BAD) || (int'(chan) >= NUM_CH);
  end

endmodule

// File: rtl/sce_delay_timer.sv
module sce_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sce_shifter.sv
module sce_shifter
  import sce_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shift_op_e     op,
  input  logic [BW-1:0] din,
  input  logic          sin,
  output logic [BW-1:0] q,
  output logic [BW-1:0] q_nxt
);

  logic [BW-1:0] q_r;

  always_comb begin
    case (op)
      SH_LOAD: q_nxt = din;
      SH_OUT:  q_nxt = {q_r[BW-2:0], 1'b0};
      SH_IN:   q_nxt = {q_r[BW-2:0], sin};
      default: q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (op != SH_HOLD) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/sce_engine.sv
module sce_engine
  import sce_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int NUM_CH     = 4,
  parameter int CH_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CH_W-1:0] chan,
  input  logic [7:0]      cmd,
  input  logic [7:0]      wbyte0,
  input  logic [7:0]      wbyte1,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [7:0]      rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NUM_CH-1:0] sel_n
);

  localparam int T1 = CYC_PER_US;
  localparam int T2 = 2 * CYC_PER_US;
  localparam int T4 = 4 * CYC_PER_US;
  localparam int TW = $clog2(T4 + 1);
  localparam logic [TW-1:0] LD1 = TW'(T1 - 1);
  localparam logic [TW-1:0] LD2 = TW'(T2 - 1);
  localparam logic [TW-1:0] LD4 = TW'(T4 - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rsync_q[1];

  // request decode
  logic [1:0] dec_nb;
  logic       dec_rd;
  logic       dec_reject;

  sce_cmd_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .code    (cmd),
    .chan    (chan),
    .nbytes  (dec_nb),
    .is_read (dec_rd),
    .reject  (dec_reject)
  );

  // registers
  eng_state_e       state_q, state_d;
  logic [CH_W-1:0]  ch_q;
  logic [7:0]       cmd_q, p0_q, p1_q;
  logic [1:0]       nb_q;
  logic             rd_q;
  logic [1:0]       byte_q, byte_d;
  logic [2:0]       bit_q, bit_d;
  logic             sclk_q, sclk_d;
  logic             mosi_q, mosi_d;
  logic [NUM_CH-1:0] seln_q, seln_d;
  logic [7:0]       rdata_q, rdata_d;
  logic             err_q, err_d;
  logic             latch;

  // timer and shifter
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;
  shift_op_e     sh_op;
  logic [7:0]    sh_din;
  logic [7:0]    sh_q;
  logic [7:0]    sh_nxt;

  sce_delay_timer #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sce_shifter #(.BW(8)) u_sh (
    .clk   (clk),
    .rst_n (rst_q_n),
    .op    (sh_op),
    .din   (sh_din),
    .sin   (miso),
    .q     (sh_q),
    .q_nxt (sh_nxt)
  );

  logic cur_rd;
  logic end_byte;
  logic last_byte;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    rdata_d  = rdata_q;
    err_d    = err_q;
    latch    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = LD1;
    sh_op    = SH_HOLD;
    sh_din   = cmd_q;
    end_byte = 1'b0;
    cur_rd   = rd_q && (byte_q != 2'd0);
    last_byte = (byte_q == (nb_q - 2'd1));

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          latch = 1'b1;
          if (dec_reject) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            err_d    = 1'b0;
            state_d  = ST_PRE;
            tmr_load = 1'b1;
            tmr_val  = LD2;
          end
        end
      end
      ST_PRE: begin
        if (tmr_exp) begin
          state_d  = ST_CSSU;
          tmr_load = 1'b1;
          tmr_val  = LD2;
        end
      end
      ST_CSSU: begin
        if (tmr_exp) begin
          sh_op    = SH_LOAD;
          sh_din   = cmd_q;
          bit_d    = 3'd0;
          byte_d   = 2'd0;
          state_d  = ST_WSU;
          tmr_load = 1'b1;
          tmr_val  = LD2;
        end
      end
      ST_WSU: begin
        if (tmr_exp) begin
          state_d  = ST_CLO;
          tmr_load = 1'b1;
          tmr_val  = LD1;
        end
      end
      ST_CLO: begin
        if (tmr_exp) begin
          state_d  = ST_CHI;
          tmr_load = 1'b1;
          tmr_val  = LD1;
        end
      end
      ST_CHI: begin
        if (tmr_exp) begin
          if (cur_rd) begin
            state_d  = ST_RSET;
            tmr_load = 1'b1;
            tmr_val  = LD2;
          end else begin
            sh_op = SH_OUT;
            if (bit_q == 3'd7) begin
              end_byte = 1'b1;
            end else begin
              bit_d    = bit_q + 3'd1;
              state_d  = ST_WSU;
              tmr_load = 1'b1;
              tmr_val  = LD2;
            end
          end
        end
      end
      ST_RSET: begin
        if (tmr_exp) begin
          sh_op = SH_IN;
          if (bit_q == 3'd7) begin
            end_byte = 1'b1;
          end else begin
            bit_d    = bit_q + 3'd1;
            state_d  = ST_CLO;
            tmr_load = 1'b1;
            tmr_val  = LD1;
          end
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          bit_d    = 3'd0;
          tmr_load = 1'b1;
          if (rd_q) begin
            state_d = ST_CLO;
            tmr_val = LD1;
          end else begin
            sh_op   = SH_LOAD;
            sh_din  = (byte_q == 2'd1) ? p0_q : p1_q;
            state_d = ST_WSU;
            tmr_val = LD2;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase

    if (end_byte) begin
      if (cur_rd) begin
        rdata_d = sh_nxt;
      end
      tmr_load = 1'b1;
      tmr_val  = LD4;
      if (last_byte) begin
        state_d = ST_HOLD;
      end else begin
        byte_d  = byte_q + 2'd1;
        state_d = ST_GAP;
      end
    end
  end

  // output next values, taken from the next state
  logic sel_window;

  always_comb begin
    sclk_d = (state_d != ST_CLO);
    sel_window = (state_d == ST_CSSU) || (state_d == ST_WSU) ||
                 (state_d == ST_CLO)  || (state_d == ST_CHI) ||
                 (state_d == ST_RSET) || (state_d == ST_GAP) ||
                 (state_d == ST_HOLD);
    if (state_d == ST_PRE && state_q == ST_IDLE) begin
      mosi_d = 1'b1;
    end else if (state_d == ST_WSU && state_q != ST_WSU) begin
      mosi_d = sh_nxt[7];
    end else begin
      mosi_d = mosi_q;
    end
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_sel
    always_comb begin
      seln_d[gi] = !(sel_window && (int'(ch_q) == gi));
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      byte_q  <= 2'd0;
      bit_q   <= 3'd0;
      sclk_q  <= 1'b1;
      mosi_q  <= 1'b1;
      seln_q  <= '1;
      rdata_q <= 8'h00;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      mosi_q  <= mosi_d;
      seln_q  <= seln_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ch_q  <= '0;
      cmd_q <= 8'h00;
      p0_q  <= 8'h00;
      p1_q  <= 8'h00;
      nb_q  <= 2'd1;
      rd_q  <= 1'b0;
    end else if (latch) begin
      ch_q  <= chan;
      cmd_q <= cmd;
      p0_q  <= wbyte0;
      p1_q  <= wbyte1;
      nb_q  <= dec_nb;
      rd_q  <= dec_rd;
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = (state_q == ST_DONE);
  assign err   = done && err_q;
  assign rdata = rdata_q;
  assign sclk  = sclk_q;
  assign mosi  = mosi_q;
  assign sel_n = seln_q;

endmodule

// File: rtl/sce_engine_chk.sv
module sce_engine_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CH_W-1:0]   chan,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CH-1:0] sel_n
);

  p_reject_chan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (int'(chan) >= NUM_CH)) |=> (done && err));

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);

  p_data_stable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> $stable(mosi));

  p_clock_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> (sel_n != '1));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_release_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_n == '1) && ($past(sel_n) != '1)) |-> done);

  p_busy_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_err_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && (sel_n == '1)));

endmodule

bind sce_engine sce_engine_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .start (start),
  .chan  (chan),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .sclk  (sclk),
  .mosi  (mosi),
  .sel_n (sel_n)
);

// File: tb/sce_engine_tb.sv
module sce_engine_tb_top;

  localparam int CYC = 2;
  localparam int NCH = 4;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] chan = '0;
  logic [7:0] cmd = 8'h00, wbyte0 = 8'h00, wbyte1 = 8'h00;
  logic busy, done, err, sclk, mosi;
  logic miso = 1'b0;
  logic [7:0] rdata;
  logic [NCH-1:0] sel_n;

  always #5 clk = ~clk;

  sce_engine #(.CYC_PER_US(CYC), .NUM_CH(NCH), .CH_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .cmd(cmd),
    .wbyte0(wbyte0), .wbyte1(wbyte1), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .sel_n(sel_n)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor / device model
  logic [23:0] cap;
  int nbits, falls, fall_ch, hi_bad, clk_bad;
  logic [7:0] reply;
  logic prev_sclk = 1'b1;
  logic prev_mosi = 1'b1;
  logic [NCH-1:0] prev_sel = '1;

  always @(negedge clk) begin
    if (prev_sel == '1 && sel_n != '1) begin
      falls++;
      for (int i = 0; i < NCH; i++) if (!sel_n[i]) fall_ch = i;
      if (mosi !== 1'b1) hi_bad++;
      if ($countones(~sel_n) != 1) hi_bad++;
    end
    if (!prev_sclk && sclk && sel_n != '1) begin
      cap = {cap[22:0], mosi};
      nbits++;
      if (nbits >= 9 && nbits <= 16) miso = reply[16 - nbits];
    end
    if (!sclk && mosi !== prev_mosi) clk_bad++;
    prev_sclk = sclk;
    prev_mosi = mosi;
    prev_sel  = sel_n;
  end

  function automatic int exp_nb(input logic [7:0] c);
    if (c == 8'h01) return 1;
    if (c >= 8'h80 && c <= 8'h87) return 2;
    if (c == 8'h00 || c == 8'hC0 || c == 8'hC1) return 2;
    if (c >= 8'hB0 && c <= 8'hB3) return 3;
    return 0;
  endfunction

  function automatic bit exp_rd(input logic [7:0] c);
    return (c == 8'h00 || c == 8'hC0 || c == 8'hC1);
  endfunction

  task automatic run(input int ch, input logic [7:0] c, input logic [7:0] b0,
                     input logic [7:0] b1, input logic [7:0] rep, input bit inject);
    int cnt, nb, expc, mask;
    bit valid;
    logic [23:0] es;
    @(negedge clk);
    cap = '0; nbits = 0; falls = 0; fall_ch = -1; hi_bad = 0; clk_bad = 0;
    reply = rep; miso = 1'b0;
    chan = CW'(ch); cmd = c; wbyte0 = b0; wbyte1 = b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 20) begin
        start = 1'b1; chan = 3'd0; cmd = 8'h01; wbyte0 = ~b0; wbyte1 = ~b1;
      end
      if (inject && cnt == 21) start = 1'b0;
    end
    nb = exp_nb(c);
    valid = (nb != 0) && (ch < NCH);
    if (!valid) begin
      chk(cnt == 0, "R1/R2 reject latency", cnt, 0);
      chk(err === 1'b1, "R1/R2 reject err", int'(err), 1);
      chk(falls == 0 && nbits == 0, "R1/R2 no bus activity", falls + nbits, 0);
    end else begin
      expc = 8 * CYC + 32 * CYC * nb + 4 * CYC * (nb - 1);
      chk(cnt == expc, "R7 transaction length", cnt, expc);
      chk(err === 1'b0, "R2 accepted no err", int'(err), 0);
      chk(nbits == 8 * nb, "R2/R4 bit count", nbits, 8 * nb);
      chk(falls == 1 && fall_ch == ch, "R3 addressed select", fall_ch, ch);
      chk(hi_bad == 0, "R3 data high at select, single select", hi_bad, 0);
      chk(clk_bad == 0, "R5 data stable while clock low", clk_bad, 0);
      if (exp_rd(c)) begin
        chk(cap[15:8] == c, "R4 read command byte", int'(cap[15:8]), int'(c));
        chk(rdata == rep, "R6 read result", int'(rdata), int'(rep));
      end else begin
        es = {c, b0, b1} >> (8 * (3 - nb));
        mask = (1 << (8 * nb)) - 1;
        chk((int'(cap) & mask) == (int'(es) & mask), "R4 stream order",
            int'(cap) & mask, int'(es) & mask);
      end
    end
    @(negedge clk);
    chk(!done && !busy && sel_n == '1 && sclk, "R8 single done and release",
        int'({done, busy, sel_n}), int'({2'b00, {NCH{1'b1}}}));
    if (inject) chk(falls == 1, "R9 start while busy ignored", falls, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(sel_n == '1 && sclk && mosi && !busy && !done && !err, "R10 reset state",
        int'({sel_n, sclk, mosi, busy, done, err}), int'({{NCH{1'b1}}, 5'b11000}));
    for (int c = 0; c < 256; c++) begin
      run(2, 8'(c), 8'hA5, 8'h3C, 8'(c) ^ 8'h5A, 1'b0);
    end
    for (int ch = 0; ch < 8; ch++) begin
      run(ch, 8'hB2, 8'(ch * 17), 8'(8'hF0 - ch), 8'h00, 1'b0);
      run(ch, 8'hC1, 8'h00, 8'h00, 8'(8'h81 ^ (ch * 37)), 1'b0);
    end
    run(1, 8'h84, 8'h96, 8'h00, 8'h00, 1'b1);
    run(3, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule